// File: doc/BRIEF.md
# Windowed Sample Capture Controller

This block records a software-chosen number of converter samples into one port of a true dual-port memory, leaving the other port free for a processor to read the finished window. Each converter cycle delivers one word per channel from two 14-bit channels together with a valid flag. Each accepted pair becomes one 32-bit memory word, with both channels widened to 16 bits.

Software uses a small register bus. It sets the window length, then writes the start bit. It polls a status word until the done flag appears, and then reads the memory through the other port. The block stops by itself after the window is full. It ignores further start requests until the capture has finished. Any window length the memory cannot hold is replaced by the full memory depth.

Top module: `win_capture_ctrl`

## Requirements
- R1: After reset, mem_we is 0. The status word (offset 2) reads 0, with busy in bit 0 and done in bit 1. The length register (offset 1) reads 0. The control register (offset 0) reads 0.
- R2: A register write to offset 0 with bit 0 set starts a capture when none is running. The start bit clears itself, so offset 0 always reads 0.
- R3: During a capture, each cycle with smp_valid high produces exactly one memory write on the following cycle. The address of the first write of a capture is 0, and each later write is one higher.
- R4: The memory word holds ch0 sign-extended to 16 bits in bits [15:0] and ch1 sign-extended to 16 bits in bits [31:16].
- R5: The capture ends after as many writes as the effective window length. Done rises in the same cycle as the last write appears, and busy falls at that point. While a capture is running, status reads busy=1 and done=0.
- R6: A length of 0, or a length greater than the memory depth (2^ADDR_W), captures exactly 2^ADDR_W samples.
- R7: A start written while a capture is running is ignored: addresses continue without restarting, and the capture ends at its original length.
- R8: A new start clears done, and the next capture again writes from address 0.
- R9: The length register (offset 1) reads back the full 32-bit value written. A length write during a capture does not change that capture's window.
- R10: Cycles with smp_valid low, and samples that arrive while no capture is running, produce no memory write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample pair present this cycle |
| smp_ch0 | input | 14 | Channel 0 converter word, two's complement |
| smp_ch1 | input | 14 | Channel 1 converter word, two's complement |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 control, 1 length, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 10 | Memory write address |
| mem_wdata | output | 32 | Memory write data, two packed lanes |

## Verification
Suppose the write counter or the stored target were corrupted. The next memory write would then carry a wrong address, or done would appear one write early or late. Either fault is visible on the memory port, or in the status word, within a single sample. A stuck busy flag appears at the next status poll as a missing done bit, or as a second start that restarts addresses. Errors in lane packing show on the very next write, in the sign bits of the data word.

// File: rtl/capture_pkg.sv
package capture_pkg;
   localparam int REG_W  = 32;
   localparam int OFS_W  = 2;

   localparam logic [OFS_W-1:0] OFS_CTRL = 2'd0;
   localparam logic [OFS_W-1:0] OFS_LEN  = 2'd1;
   localparam logic [OFS_W-1:0] OFS_STAT = 2'd2;

   localparam int STAT_BUSY_BIT = 0;
   localparam int STAT_DONE_BIT = 1;

   typedef struct packed {
      logic done;
      logic busy;
   } cap_status_t;
endpackage

// File: rtl/sample_packer.sv
module sample_packer #(
   parameter int SAMPLE_W = 14,
   parameter int LANE_W   = 16,
   parameter int NUM_CH   = 2,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic [NUM_CH*SAMPLE_W-1:0] raw_in,
   output logic [NUM_CH*LANE_W-1:0]   word_out
);
   localparam int PAD_W = LANE_W - SAMPLE_W;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
      logic [SAMPLE_W-1:0] smp;
      assign smp = raw_in[ch*SAMPLE_W +: SAMPLE_W];
      if (PAD_W == 0) begin : g_nopad
         assign word_out[ch*LANE_W +: LANE_W] = smp;
      end else if (SIGN_EXT) begin : g_sext
         assign word_out[ch*LANE_W +: LANE_W] = {{PAD_W{smp[SAMPLE_W-1]}}, smp};
      end else begin : g_zext
         assign word_out[ch*LANE_W +: LANE_W] = {{PAD_W{1'b0}}, smp};
      end
   end
endmodule

// File: rtl/capture_regs.sv
module capture_regs
   import capture_pkg::*;
#(
   parameter int ADDR_W = 10,
   localparam int LEN_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [OFS_W-1:0]  reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   input  cap_status_t       status,
   output logic              start_req,
   output logic [LEN_W-1:0]  win_len,
   output logic [REG_W-1:0]  reg_rdata
);
   localparam logic [REG_W-1:0] DEPTH_W = REG_W'(1) << ADDR_W;

   logic [REG_W-1:0] len_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         len_q <= '0;
      end else if (reg_wr && reg_addr == OFS_LEN) begin
         len_q <= reg_wdata;
      end
   end

   // start is a write-only strobe: nothing is stored, so it reads as zero
   assign start_req = reg_wr && (reg_addr == OFS_CTRL) && reg_wdata[0];

   always_comb begin
      if (len_q == '0 || len_q > DEPTH_W) begin
         win_len = DEPTH_W[LEN_W-1:0];
      end else begin
         win_len = len_q[LEN_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_LEN:  reg_rdata = len_q;
         OFS_STAT: begin
            reg_rdata[STAT_BUSY_BIT] = status.busy;
            reg_rdata[STAT_DONE_BIT] = status.done;
         end
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/capture_seq.sv
module capture_seq #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   localparam int LEN_W = ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_req,
   input  logic [LEN_W-1:0]  win_len,
   input  logic              smp_valid,
   input  logic [DATA_W-1:0] smp_word,
   output logic              busy,
   output logic              done,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata
);
   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] last_q;
   logic             is_last;

   assign is_last = (cnt_q == last_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         done      <= 1'b0;
         cnt_q     <= '0;
         last_q    <= '0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
      end else begin
         mem_we <= 1'b0;
         if (busy) begin
            if (smp_valid) begin
               mem_we    <= 1'b1;
               mem_addr  <= cnt_q[ADDR_W-1:0];
               mem_wdata <= smp_word;
               cnt_q     <= cnt_q + 1'b1;
               if (is_last) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end else if (start_req) begin
            busy   <= 1'b1;
            done   <= 1'b0;
            cnt_q  <= '0;
            last_q <= win_len - 1'b1;
         end
      end
   end
endmodule

// File: rtl/win_capture_ctrl.sv
module win_capture_ctrl
   import capture_pkg::*;
#(
   parameter int SAMPLE_W = 14,
   parameter int LANE_W   = 16,
   parameter int ADDR_W   = 10,
   parameter bit SIGN_EXT = 1'b1,
   localparam int NUM_CH  = 2,
   localparam int DATA_W  = NUM_CH * LANE_W,
   localparam int LEN_W   = ADDR_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_ch0,
   input  logic [SAMPLE_W-1:0] smp_ch1,
   input  logic                reg_wr,
   input  logic [OFS_W-1:0]    reg_addr,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_wdata
);
   if (LANE_W < SAMPLE_W) begin : g_bad_lane
      $error("LANE_W must be at least SAMPLE_W");
   end
   if (ADDR_W < 1 || ADDR_W > 30) begin : g_bad_addr
      $error("ADDR_W must lie in 1..30");
   end

   logic              start_req;
   logic [LEN_W-1:0]  win_len;
   logic [DATA_W-1:0] packed_word;
   logic              cap_busy;
   logic              cap_done;
   cap_status_t       status;

   assign status.busy = cap_busy;
   assign status.done = cap_done;

   capture_regs #(.ADDR_W(ADDR_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .status    (status),
      .start_req (start_req),
      .win_len   (win_len),
      .reg_rdata (reg_rdata)
   );

   sample_packer #(
      .SAMPLE_W (SAMPLE_W),
      .LANE_W   (LANE_W),
      .NUM_CH   (NUM_CH),
      .SIGN_EXT (SIGN_EXT)
   ) i_pack (
      .raw_in   ({smp_ch1, smp_ch0}),
      .word_out (packed_word)
   );

   capture_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_req (start_req),
      .win_len   (win_len),
      .smp_valid (smp_valid),
      .smp_word  (packed_word),
      .busy      (cap_busy),
      .done      (cap_done),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );
endmodule

// File: rtl/capture_chk.sv
module capture_chk #(
   parameter int ADDR_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              smp_valid,
   input logic              reg_wr,
   input logic [1:0]        reg_addr,
   input logic              start_bit,
   input logic              busy,
   input logic              done,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr
);
   logic start_seen;
   assign start_seen = reg_wr && reg_addr == 2'd0 && start_bit;

   // R5
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   // R10
   write_needs_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ($past(busy) && $past(smp_valid)));

   // R3
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + 1'b1));

   // R5
   done_with_last_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> mem_we);

   // R8
   start_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_seen && !busy) |=> (busy && !done));

   // R7
   start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_seen && busy && !smp_valid) |=> busy);
endmodule

bind win_capture_ctrl capture_chk #(.ADDR_W(ADDR_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_valid (smp_valid),
   .reg_wr    (reg_wr),
   .reg_addr  (reg_addr),
   .start_bit (reg_wdata[0]),
   .busy      (cap_busy),
   .done      (cap_done),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr)
);

// File: tb/test_win_capture_ctrl.sv
module test_win_capture_ctrl;
   localparam int AW    = 10;
   localparam int DEPTH = 1 << AW;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [13:0] smp_ch0 = '0;
   logic [13:0] smp_ch1 = '0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;

   always #2ns clk = ~clk;

   win_capture_ctrl #(.ADDR_W(AW)) i_win_capture_ctrl (
      .clk, .rst_n, .smp_valid, .smp_ch0, .smp_ch1,
      .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .mem_we, .mem_addr, .mem_wdata
   );

   int total = 0;
   int bad = 0;

   // bench model state
   bit          e_we = 1'b0;
   int          e_addr = 0;
   logic [31:0] e_data = '0;
   bit          mbusy = 1'b0;
   bit          mdone = 1'b0;
   int          mcnt = 0;
   int          mtgt = 0;
   logic [31:0] mlen = '0;

   function automatic logic [31:0] pack(input logic [13:0] a, input logic [13:0] b);
      return {{2{b[13]}}, b, {2{a[13]}}, a};
   endfunction

   function automatic int clamp(input logic [31:0] l);
      if (l == 0 || l > DEPTH) return DEPTH;
      return int'(l);
   endfunction

   function automatic logic [31:0] model_rd(input logic [1:0] a);
      case (a)
         2'd1:    return mlen;
         2'd2:    return {30'd0, mdone, mbusy};
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input bit wr, input logic [1:0] a, input logic [31:0] wd,
                      input bit v, input logic [13:0] c0, input logic [13:0] c1,
                      input bit rd_chk, input string tag);
      @(negedge clk);
      check("R3/R10", "mem_we", {31'd0, mem_we}, {31'd0, e_we});
      if (e_we && mem_we) begin
         check("R3", "mem_addr", {{(32-AW){1'b0}}, mem_addr}, 32'(e_addr));
         check("R4", "mem_wdata", mem_wdata, e_data);
      end
      reg_wr = wr; reg_addr = a; reg_wdata = wd;
      smp_valid = v; smp_ch0 = c0; smp_ch1 = c1;
      #1;
      if (rd_chk) check(tag, "reg_rdata", reg_rdata, model_rd(a));
      e_we = 1'b0;
      if (mbusy) begin
         if (v) begin
            e_we = 1'b1; e_addr = mcnt; e_data = pack(c0, c1);
            mcnt++;
            if (mcnt == mtgt) begin mbusy = 1'b0; mdone = 1'b1; end
         end
      end else if (wr && a == 2'd0 && wd[0]) begin
         mbusy = 1'b1; mdone = 1'b0; mcnt = 0; mtgt = clamp(mlen);
      end
      if (wr && a == 2'd1) mlen = wd;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(0, 2'd3, 0, 0, 0, 0, 0, "");
   endtask

   task automatic rd(input logic [1:0] a, input string tag);
      cyc(0, a, 0, 0, 0, 0, 1, tag);
   endtask

   task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
      cyc(1, a, d, 0, 0, 0, 0, "");
   endtask

   task automatic stream(input int n, input int pct);
      for (int i = 0; i < n; i++)
         cyc(0, 2'd3, 0, ($urandom % 100) < pct, 14'($urandom), 14'($urandom), 0, "");
   endtask

   initial begin
      #400us;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total + 1, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(2'd2, "R1");
      rd(2'd1, "R1");
      rd(2'd0, "R1");

      // R10 samples with no capture running
      for (int i = 0; i < 4; i++) cyc(0, 2'd3, 0, 1, 14'h1fff, 14'h2000, 0, "");

      // R9 length readback, R2 start and control readback
      wr_reg(2'd1, 32'd5);
      rd(2'd1, "R9");
      wr_reg(2'd0, 32'd1);
      rd(2'd0, "R2");
      rd(2'd2, "R5");
      // R4 directed sign corners
      cyc(0, 2'd3, 0, 1, 14'h2000, 14'h1fff, 0, "");
      cyc(0, 2'd3, 0, 1, 14'h3fff, 14'h0000, 0, "");
      stream(12, 60);
      rd(2'd2, "R5");

      // R8 done clears on restart
      wr_reg(2'd1, 32'd3);
      wr_reg(2'd0, 32'd1);
      rd(2'd2, "R8");
      stream(10, 100);
      rd(2'd2, "R8");

      // random windows with start-while-busy (R7) and length rewrite (R9)
      for (int it = 0; it < 10; it++) begin
         wr_reg(2'd1, 32'(1 + $urandom % 40));
         rd(2'd1, "R9");
         wr_reg(2'd0, 32'd1);
         stream(3, 70);
         cyc(1, 2'd0, 32'd1, 0, 0, 0, 0, "");
         cyc(1, 2'd0, 32'd1, 1, 14'($urandom), 14'($urandom), 0, "");
         wr_reg(2'd1, 32'(1 + $urandom % 40));
         stream(120, 20 + $urandom % 70);
         rd(2'd2, "R7");
      end

      // R6 zero length clamps to depth
      wr_reg(2'd1, 32'd0);
      wr_reg(2'd0, 32'd1);
      stream(DEPTH + 8, 100);
      rd(2'd2, "R6");
      // R6 oversize length clamps to depth
      wr_reg(2'd1, 32'd2000);
      wr_reg(2'd0, 32'd1);
      stream(DEPTH / 2, 100);
      rd(2'd2, "R6");
      stream(DEPTH / 2 + 8, 100);
      rd(2'd2, "R6");
      rd(2'd1, "R9");
      idle(2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule